// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block cleans one asynchronous input signal of contact bounce and short glitches. The input is brought into a slow filter clock domain through a two-flop synchronizer. A 16-bit down-counter then measures how long the synchronized value has differed from the current filtered output. Only after the difference has persisted for the programmed number of filter clock edges does the filtered output take the new value. If the input returns to the output value before that, the count starts over.

A host bus running on a much faster clock programs the stability amount and can overwrite the live counter at any moment. Both kinds of write cross into the filter domain through a single toggle request/acknowledge channel. The host's data is held steady until the filter domain has taken it. In the other direction, the filter domain repeatedly captures the counter into a holding register on request. The host copies that register only after the acknowledge comes back, so the count it presents is always a whole value. A filter enable freezes the filtering logic as if its clock were stopped. Host writes and count snapshots still go through while it is low.

Top module: `dbf_top`

## Requirements
- R1: After reset the filtered output is 0, `busy_o` is 0, the stored amount and the counter are 0, and `rd_count_o` reads 0.
- R2: With amount N and the enable high, a change of `raw_i` made mid-period becomes visible on `flt_out_o` exactly max(N,1)+2 filter clock edges later and not one edge earlier. Two of those edges are spent in the synchronizer.
- R3: A deviation of the synchronized input that lasts fewer than max(N,1) enabled edges leaves `flt_out_o` unchanged. A return to the output value reloads the full amount, so two such short pulses separated by one matching edge also leave the output unchanged.
- R4: While the synchronized input equals the output, the counter reloads the amount on every enabled edge, so `rd_count_o` settles to the programmed amount. This holds for all amounts up to 0xFFFF.
- R5: The counter never wraps below zero. An amount of 0 behaves like 1, so the output follows the synchronized input on the first differing edge.
- R6: `wr_i` with `busy_o` low is accepted. `wr_sel_i`=0 selects the amount and `wr_sel_i`=1 selects the counter. `busy_o` stays high until the filter domain has applied the value, and `wr_i` while `busy_o` is high is ignored.
- R7: A counter write takes priority over that edge's reload or decrement. If C (C≥1) is written while the input differs, the output changes on the C-th enabled edge after the edge that applied the write.
- R8: `rd_count_o` always shows a complete counter value captured in the filter domain, and it is refreshed continuously without any host action.
- R9: With `flt_en_i` low, the synchronizer, counter and output hold their values and `raw_i` changes have no effect. Host writes and snapshots are still carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk_i | input | 1 | Host bus clock |
| host_rst_ni | input | 1 | Host domain reset, active low |
| wr_i | input | 1 | Write strobe, taken when busy_o is low |
| wr_sel_i | input | 1 | Write target: 0 amount, 1 counter |
| wr_data_i | input | 16 | Write value |
| busy_o | output | 1 | A write is still crossing to the filter domain |
| rd_count_o | output | 16 | Latest captured counter value |
| flt_clk_i | input | 1 | Slow filter clock |
| flt_rst_ni | input | 1 | Filter domain reset, active low |
| flt_en_i | input | 1 | Filter enable, sampled on the filter clock |
| raw_i | input | 1 | Asynchronous raw input |
| flt_out_o | output | 1 | Debounced output |

## Verification
The counter write and the filter's own reload or decrement can land on the same filter edge. The write must win. This is provoked by jamming a small count while the input has been differing for several edges under a large amount, so the counter is decrementing on the very edge that applies the write. The test is judged by timing the output flip relative to the edge on which `busy_o` reports completion: it must come exactly C edges later, not after the large amount. A second collision, an amount write arriving while a previous write is still pending, is judged by reading back the amount that actually took effect.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    typedef enum logic {
        WR_AMOUNT = 1'b0,
        WR_COUNT  = 1'b1
    } wr_kind_e;

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (en_i) begin
            chain_d[0] = d_i;
            for (int i = 1; i < int'(STAGES); i++) begin
                chain_d[i] = chain_q[i-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dbf_host_if.sv
module dbf_host_if
    import dbf_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  wr_kind_e         wr_kind_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             busy_o,
    output logic             req_tgl_o,
    output wr_kind_e         kind_o,
    output logic [CNT_W-1:0] data_o,
    input  logic             ack_tgl_i,
    output logic             snap_req_o,
    input  logic             snap_ack_i,
    input  logic [CNT_W-1:0] snap_data_i,
    output logic [CNT_W-1:0] rd_count_o
);

    localparam int unsigned BACK_W = 2;

    typedef struct packed {
        logic             req;
        wr_kind_e         kind;
        logic [CNT_W-1:0] data;
        logic             snap;
        logic [CNT_W-1:0] rd;
    } host_st_t;

    host_st_t st_d, st_q;
    logic [BACK_W-1:0] back_s;
    logic ack_s, snap_ack_s, busy;

    dbf_sync #(.WIDTH(BACK_W), .STAGES(SYNC_STAGES)) u_back_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (1'b1),
        .d_i    ({ack_tgl_i, snap_ack_i}),
        .q_o    (back_s)
    );

    assign ack_s      = back_s[1];
    assign snap_ack_s = back_s[0];
    assign busy       = (st_q.req != ack_s);

    always_comb begin
        st_d = st_q;
        if (wr_i && !busy) begin
            st_d.req  = ~st_q.req;
            st_d.kind = wr_kind_i;
            st_d.data = wr_data_i;
        end
        if (snap_ack_s == st_q.snap) begin
            st_d.rd   = snap_data_i;
            st_d.snap = ~st_q.snap;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o     = busy;
    assign req_tgl_o  = st_q.req;
    assign kind_o     = st_q.kind;
    assign data_o     = st_q.data;
    assign snap_req_o = st_q.snap;
    assign rd_count_o = st_q.rd;

endmodule

// File: rtl/dbf_core.sv
module dbf_core
    import dbf_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             raw_i,
    input  logic             req_tgl_i,
    input  wr_kind_e         kind_i,
    input  logic [CNT_W-1:0] data_i,
    output logic             ack_tgl_o,
    input  logic             snap_req_i,
    output logic             snap_ack_o,
    output logic [CNT_W-1:0] snap_data_o,
    output logic             out_o,
    output logic             raw_s_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] amt_o,
    output logic             apply_o
);

    localparam int unsigned      FWD_W    = 2;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(1);

    typedef struct packed {
        logic             out;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] amt;
        logic             seen;
        logic             snap_ack;
        logic [CNT_W-1:0] hold;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [FWD_W-1:0] fwd_s;
    logic raw_s, req_s, snap_s, apply;

    dbf_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_raw_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .d_i    (raw_i),
        .q_o    (raw_s)
    );

    dbf_sync #(.WIDTH(FWD_W), .STAGES(SYNC_STAGES)) u_fwd_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (1'b1),
        .d_i    ({req_tgl_i, snap_req_i}),
        .q_o    (fwd_s)
    );

    assign req_s  = fwd_s[1];
    assign snap_s = fwd_s[0];
    assign apply  = (req_s != st_q.seen);

    always_comb begin
        st_d = st_q;
        if (apply) begin
            st_d.seen = req_s;
            if (kind_i == WR_COUNT) st_d.cnt = data_i;
            else                    st_d.amt = data_i;
        end else if (en_i) begin
            if (raw_s == st_q.out) begin
                st_d.cnt = st_q.amt;
            end else if (st_q.cnt <= LAST_CNT) begin
                st_d.out = raw_s;
                st_d.cnt = st_q.amt;
            end else begin
                st_d.cnt = st_q.cnt - LAST_CNT;
            end
        end
        if (snap_s != st_q.snap_ack) begin
            st_d.hold     = st_q.cnt;
            st_d.snap_ack = snap_s;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ack_tgl_o   = st_q.seen;
    assign snap_ack_o  = st_q.snap_ack;
    assign snap_data_o = st_q.hold;
    assign out_o       = st_q.out;
    assign raw_s_o     = raw_s;
    assign cnt_o       = st_q.cnt;
    assign amt_o       = st_q.amt;
    assign apply_o     = apply;

endmodule

// File: rtl/dbf_top.sv
module dbf_top
    import dbf_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             host_clk_i,
    input  logic             host_rst_ni,
    input  logic             wr_i,
    input  logic             wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] rd_count_o,
    input  logic             flt_clk_i,
    input  logic             flt_rst_ni,
    input  logic             flt_en_i,
    input  logic             raw_i,
    output logic             flt_out_o
);

    logic             req_tgl, ack_tgl, snap_req, snap_ack;
    wr_kind_e         host_kind;
    logic [CNT_W-1:0] host_data, snap_data;
    logic             raw_s, apply;
    logic [CNT_W-1:0] cnt, amt;

    dbf_host_if #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_host (
        .clk_i       (host_clk_i),
        .rst_ni      (host_rst_ni),
        .wr_i        (wr_i),
        .wr_kind_i   (wr_kind_e'(wr_sel_i)),
        .wr_data_i   (wr_data_i),
        .busy_o      (busy_o),
        .req_tgl_o   (req_tgl),
        .kind_o      (host_kind),
        .data_o      (host_data),
        .ack_tgl_i   (ack_tgl),
        .snap_req_o  (snap_req),
        .snap_ack_i  (snap_ack),
        .snap_data_i (snap_data),
        .rd_count_o  (rd_count_o)
    );

    dbf_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .clk_i       (flt_clk_i),
        .rst_ni      (flt_rst_ni),
        .en_i        (flt_en_i),
        .raw_i       (raw_i),
        .req_tgl_i   (req_tgl),
        .kind_i      (host_kind),
        .data_i      (host_data),
        .ack_tgl_o   (ack_tgl),
        .snap_req_i  (snap_req),
        .snap_ack_o  (snap_ack),
        .snap_data_o (snap_data),
        .out_o       (flt_out_o),
        .raw_s_o     (raw_s),
        .cnt_o       (cnt),
        .amt_o       (amt),
        .apply_o     (apply)
    );

endmodule

// File: rtl/dbf_checker.sv
module dbf_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             host_clk,
    input logic             host_rst_n,
    input logic             wr,
    input logic             busy,
    input logic [CNT_W-1:0] hold_data,
    input logic             flt_clk,
    input logic             flt_rst_n,
    input logic             flt_en,
    input logic             out,
    input logic             raw_s,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] amt,
    input logic             apply
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_out_needs_mismatch_R2: assert property (@(posedge flt_clk) disable iff (!flt_rst_n)
        !$stable(out) |-> $past(raw_s != out));

    assert_reload_when_equal_R4: assert property (@(posedge flt_clk) disable iff (!flt_rst_n)
        (flt_en && !apply && raw_s == out) |=> (cnt == $past(amt)));

    assert_no_wrap_R5: assert property (@(posedge flt_clk) disable iff (!flt_rst_n)
        (flt_en && !apply && raw_s != out && cnt <= ONE) |=> (out == $past(raw_s)));

    assert_frozen_when_off_R9: assert property (@(posedge flt_clk) disable iff (!flt_rst_n)
        (!flt_en && !apply) |=> ($stable(out) && $stable(cnt)));

    assert_busy_from_write_R6: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        $rose(busy) |-> $past(wr));

    assert_data_held_while_busy_R6: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (busy && $past(busy)) |-> $stable(hold_data));

endmodule

bind dbf_top dbf_checker #(.CNT_W(CNT_W)) u_checker (
    .host_clk   (host_clk_i),
    .host_rst_n (host_rst_ni),
    .wr         (wr_i),
    .busy       (busy_o),
    .hold_data  (host_data),
    .flt_clk    (flt_clk_i),
    .flt_rst_n  (flt_rst_ni),
    .flt_en     (flt_en_i),
    .out        (flt_out_o),
    .raw_s      (raw_s),
    .cnt        (cnt),
    .amt        (amt),
    .apply      (apply)
);

// File: tb/tb_dbf_top.sv
`timescale 1ns/1ps
module tb_dbf_top;

    localparam int CW = 16;

    logic          hclk = 1'b0;
    logic          fclk = 1'b0;
    logic          hrst_n, frst_n;
    logic          wr, wr_sel, en, raw;
    logic [CW-1:0] wr_data;
    logic          busy, fout;
    logic [CW-1:0] rd_count;

    int n_chk  = 0;
    int n_fail = 0;

    dbf_top #(.CNT_W(CW), .SYNC_STAGES(2)) dut (
        .host_clk_i  (hclk),
        .host_rst_ni (hrst_n),
        .wr_i        (wr),
        .wr_sel_i    (wr_sel),
        .wr_data_i   (wr_data),
        .busy_o      (busy),
        .rd_count_o  (rd_count),
        .flt_clk_i   (fclk),
        .flt_rst_ni  (frst_n),
        .flt_en_i    (en),
        .raw_i       (raw),
        .flt_out_o   (fout)
    );

    always #2 hclk = ~hclk;
    initial begin
        #3;
        forever #20 fclk = ~fclk;
    end

    function automatic int settle_edges(int amount);
        return ((amount <= 1) ? 1 : amount) + 2;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fwait(input int n);
        repeat (n) @(posedge fclk);
        #1;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge hclk);
            guard++;
        end
    endtask

    task automatic host_wr(input bit sel, input logic [CW-1:0] val);
        @(negedge hclk);
        wr = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge hclk);
        wr = 1'b0;
        wait_idle();
    endtask

    task automatic read_cnt(output logic [CW-1:0] v);
        @(negedge hclk);
        v = rd_count;
    endtask

    task automatic set_raw(input logic v);
        @(negedge fclk);
        raw = v;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [CW-1:0] rv;
        logic          v;
        int            amt, k;
        void'($urandom(32'd1357));
        hrst_n = 1'b0; frst_n = 1'b0;
        wr = 1'b0; wr_sel = 1'b0; wr_data = '0; en = 1'b1; raw = 1'b0;
        fwait(4);
        @(negedge hclk);
        hrst_n = 1'b1; frst_n = 1'b1;

        // R1: reset state
        fwait(1);
        check(fout == 1'b0, "R1 out", fout, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        fwait(10);
        read_cnt(rv);
        check(rv == '0, "R1 readback", rv, 0);

        // R5: default amount zero passes input after the synchronizer
        set_raw(1'b1);
        fwait(2);
        check(fout == 1'b0, "R5 zero amount early", fout, 0);
        fwait(1);
        check(fout == 1'b1, "R5 zero amount", fout, 1);
        set_raw(1'b0);
        fwait(3);
        check(fout == 1'b0, "R5 zero amount fall", fout, 0);

        // R6: second write while busy is ignored
        @(negedge hclk);
        wr = 1'b1; wr_sel = 1'b0; wr_data = 16'd5;
        @(negedge hclk);
        check(busy == 1'b1, "R6 busy after write", busy, 1);
        wr_data = 16'd9;
        @(negedge hclk);
        wr = 1'b0;
        wait_idle();
        check(busy == 1'b0, "R6 busy clears", busy, 0);
        fwait(10);
        read_cnt(rv);
        check(rv == 16'd5, "R6 ignored write", rv, 5);

        // R4: largest amount reloads while equal
        host_wr(1'b0, 16'hFFFF);
        fwait(10);
        read_cnt(rv);
        check(rv == 16'hFFFF, "R4 max amount", rv, 16'hFFFF);

        // Random amounts: R2 timing, R3 glitches, R4 and R8 readback
        for (int it = 0; it < 16; it++) begin
            amt = (it < 2) ? it : int'($urandom % 14);
            host_wr(1'b0, CW'(amt));
            fwait(10);
            read_cnt(rv);
            check(rv == CW'(amt), "R4 R8 reload readback", rv, amt);
            v = ~fout;
            k = settle_edges(amt);
            set_raw(v);
            fwait(k - 1);
            check(fout == ~v, "R2 output too early", fout, ~v);
            fwait(1);
            check(fout == v, "R2 output on time", fout, v);
            if (amt >= 2) begin
                set_raw(~v);
                repeat (amt - 1) @(negedge fclk);
                raw = v;
                @(negedge fclk);
                raw = ~v;
                repeat (amt - 1) @(negedge fclk);
                raw = v;
                fwait(amt + 4);
                check(fout == v, "R3 glitches rejected", fout, v);
            end
        end

        // R9: disabled filter ignores input, still takes writes
        v = fout;
        read_cnt(rv);
        @(negedge fclk);
        en = 1'b0;
        set_raw(~v);
        fwait(20);
        check(fout == v, "R9 output frozen", fout, v);
        begin
            logic [CW-1:0] rv2;
            read_cnt(rv2);
            check(rv2 == rv, "R9 counter frozen", rv2, rv);
        end
        host_wr(1'b1, 16'h1234);
        fwait(10);
        read_cnt(rv);
        check(rv == 16'h1234, "R9 write while off", rv, 16'h1234);
        set_raw(v);
        @(negedge fclk);
        en = 1'b1;
        fwait(12);
        check(fout == v, "R9 resume stable", fout, v);

        // R7: counter write collides with a decrement edge
        host_wr(1'b0, 16'h0200);
        fwait(3);
        v = ~fout;
        set_raw(v);
        fwait(6);
        host_wr(1'b1, 16'd4);
        check(fout == ~v, "R7 at apply", fout, ~v);
        fwait(3);
        check(fout == ~v, "R7 before jam expiry", fout, ~v);
        fwait(1);
        check(fout == v, "R7 jam expiry", fout, v);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule